// File: doc/BRIEF.md
# Write-Only Key Vault

The key vault keeps symmetric cipher and MAC keys in a small bank of slots, each able to hold up to sixteen 32-bit words. A configuration port binds each slot to one pipe ID. After that, only that pipe may load the slot through the word-write port. The bus read port never returns key material. Key-space reads come back as zero, and only a single status word (valid flags, wear-limit flags, sticky error) can be read. A cipher datapath asks for a key by slot and pipe. It receives the full key one cycle later, together with a grant flag, or an all-zero key when the request is refused.

The vault also tracks wear for Triple-DES use. Each completed 64-bit block strobed against a slot bumps that slot's usage counter. When the count reaches the limit (65536 blocks by default), further Triple-DES requests for the slot are refused until a fresh key is loaded. A reset event zeroizes every key, ownership binding, counter and flag.

Top module: `key_vault`

## Requirements
- R1: A bus read of any address other than the status address returns zero on `rd_data` one cycle after `rd_en`, whatever the slots hold.
- R2: A read of the status address (`rd_addr` = MSB set, all other bits zero) returns one cycle later bit s = valid flag of slot s (bits 0..NUM_SLOTS-1), bit NUM_SLOTS+s = wear-limit flag of slot s, bit 2*NUM_SLOTS = sticky error; other bits zero.
- R3: Reset clears all key words, ownership bindings, valid flags, usage counters and the error bit, so the status reads zero and no key can be granted afterwards.
- R4: An ownership write (`own_en`) binds a slot to `own_pipe` and clears that slot's key words, valid flag and usage counter.
- R5: A word write to a slot that is unbound, or bound to a pipe other than `wr_pipe`, leaves the slot unchanged and sets the sticky error bit.
- R6: An accepted write to word 0 clears all other words of the slot, so a new key replaces the old one entirely. Any accepted write clears the usage counter. An accepted write clears the valid flag unless `wr_last` is set, in which case valid is set.
- R7: `use_req` yields, one cycle later, `key_ok`=1 and `key_out` = the slot's words (word w at bits w*32 upward) only if the slot is valid and bound to `use_pipe`. Otherwise `key_ok`=0 and `key_out` is zero, and a refused request sets the error bit.
- R8: Each `blk_done` strobe on a valid slot adds one to its usage counter. The counter saturates at the wear limit (default 65536), where the slot's limit flag is set.
- R9: A request with `use_tdes`=1 on a slot whose limit flag is set is refused with a zero key. A request with `use_tdes`=0 on the same slot is still granted.
- R10: The error bit stays set until reset; no later activity clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; zeroizes all state |
| own_en | input | 1 | Bind a slot to a pipe |
| own_slot | input | SLOT_W | Slot to bind |
| own_pipe | input | PIPE_W | Owning pipe ID |
| wr_en | input | 1 | Key word write strobe |
| wr_slot | input | SLOT_W | Target slot |
| wr_pipe | input | PIPE_W | Requesting pipe ID |
| wr_word | input | WOFS_W | Word offset within the slot |
| wr_data | input | WORD_W | Key word |
| wr_last | input | 1 | Final word of the key; sets valid |
| rd_en | input | 1 | Bus read strobe |
| rd_addr | input | ADDR_W | Read address; MSB set with zeros below = status |
| rd_data | output | WORD_W | Read data, one cycle after `rd_en` |
| use_req | input | 1 | Key request from the cipher datapath |
| use_slot | input | SLOT_W | Requested slot |
| use_pipe | input | PIPE_W | Requesting pipe ID |
| use_tdes | input | 1 | Request is for Triple-DES use |
| key_out | output | NWORDS*WORD_W | Granted key, zero when refused |
| key_ok | output | 1 | Key grant, one cycle after `use_req` |
| blk_done | input | 1 | One 64-bit Triple-DES block processed |
| blk_slot | input | SLOT_W | Slot the processed block used |

## Verification
Every result arrives exactly one clock edge after its stimulus. A word or ownership write shows in the status word read that follows. `rd_data` answers the read issued one edge earlier. `key_out` and `key_ok` answer the request issued one edge earlier, and each `blk_done` strobe moves the counter at the same edge. The bench drives each stimulus on a falling edge and samples on the next falling edge, which lands half a period after the single register stage that produces each output. The wear test issues 65535 strobes and then one more, so the limit flag is seen clear and then set at exactly the boundary.

// File: rtl/kv_pkg.sv
package kv_pkg;

   // Why a key request was refused (KV_DENY_NONE = granted)
   typedef enum logic [1:0] {
      KV_DENY_NONE    = 2'd0,
      KV_DENY_OWNER   = 2'd1,
      KV_DENY_INVALID = 2'd2,
      KV_DENY_WEAR    = 2'd3
   } kv_deny_e;

   localparam int KV_DEF_WORD_W = 32;
   localparam int KV_DEF_NWORDS = 16;
   localparam int KV_DEF_LIMIT  = 65536;

endpackage

// File: rtl/kv_use_cnt.sv
module kv_use_cnt #(
   parameter  int LIMIT = kv_pkg::KV_DEF_LIMIT,
   localparam int CNT_W = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   output logic at_limit_o
);

   localparam logic [CNT_W-1:0] LIM_V = CNT_W'(LIMIT);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (inc_i && (cnt_q != LIM_V)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign at_limit_o = (cnt_q == LIM_V);

endmodule

// File: rtl/kv_slot.sv
module kv_slot #(
   parameter  int WORD_W = kv_pkg::KV_DEF_WORD_W,
   parameter  int NWORDS = kv_pkg::KV_DEF_NWORDS,
   parameter  int PIPE_W = 3,
   parameter  int LIMIT  = kv_pkg::KV_DEF_LIMIT,
   localparam int WOFS_W = $clog2(NWORDS),
   localparam int KEY_W  = NWORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_set_i,
   input  logic [PIPE_W-1:0] own_pipe_i,
   input  logic              wr_req_i,
   input  logic [PIPE_W-1:0] wr_pipe_i,
   input  logic [WOFS_W-1:0] wr_word_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic              wr_last_i,
   input  logic              blk_inc_i,
   output logic [KEY_W-1:0]  key_o,
   output logic              valid_o,
   output logic              owned_o,
   output logic [PIPE_W-1:0] owner_o,
   output logic              limit_o,
   output logic              wr_block_o
);

   logic [WORD_W-1:0] words_q [NWORDS];
   logic [PIPE_W-1:0] owner_q;
   logic              owned_q;
   logic              valid_q;
   logic              wr_ok;

   assign wr_ok      = wr_req_i && owned_q && (wr_pipe_i == owner_q);
   assign wr_block_o = wr_req_i && !wr_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= '0;
         owned_q <= 1'b0;
         valid_q <= 1'b0;
         for (int k = 0; k < NWORDS; k++) begin
            words_q[k] <= '0;
         end
      end else if (own_set_i) begin
         owner_q <= own_pipe_i;
         owned_q <= 1'b1;
         valid_q <= 1'b0;
         for (int k = 0; k < NWORDS; k++) begin
            words_q[k] <= '0;
         end
      end else if (wr_ok) begin
         valid_q <= wr_last_i;
         for (int k = 0; k < NWORDS; k++) begin
            if (wr_word_i == WOFS_W'(k)) begin
               words_q[k] <= wr_data_i;
            end else if (wr_word_i == '0) begin
               words_q[k] <= '0;
            end
         end
      end
   end

   generate
      for (genvar g = 0; g < NWORDS; g++) begin : g_pack
         assign key_o[g*WORD_W +: WORD_W] = words_q[g];
      end
   endgenerate

   kv_use_cnt #(
      .LIMIT (LIMIT)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (own_set_i | wr_ok),
      .inc_i      (blk_inc_i & valid_q),
      .at_limit_o (limit_o)
   );

   assign valid_o = valid_q;
   assign owned_o = owned_q;
   assign owner_o = owner_q;

endmodule

// File: rtl/kv_rd_port.sv
module kv_rd_port #(
   parameter int WORD_W = kv_pkg::KV_DEF_WORD_W,
   parameter int ADDR_W = 7,
   parameter int STAT_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [STAT_W-1:0] status_i,
   output logic [WORD_W-1:0] rd_data_o
);

   localparam logic [ADDR_W-1:0] STAT_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};

   // Only the status word is ever visible; key space reads as zero
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data_o <= '0;
      end else if (rd_en_i && (rd_addr_i == STAT_ADDR)) begin
         rd_data_o <= WORD_W'(status_i);
      end else begin
         rd_data_o <= '0;
      end
   end

endmodule

// File: rtl/key_vault.sv
module key_vault #(
   parameter  int NUM_SLOTS  = 4,
   parameter  int WORD_W     = kv_pkg::KV_DEF_WORD_W,
   parameter  int NWORDS     = kv_pkg::KV_DEF_NWORDS,
   parameter  int PIPE_W     = 3,
   parameter  int WEAR_LIMIT = kv_pkg::KV_DEF_LIMIT,
   localparam int SLOT_W     = $clog2(NUM_SLOTS),
   localparam int WOFS_W     = $clog2(NWORDS),
   localparam int KEY_W      = NWORDS * WORD_W,
   localparam int ADDR_W     = SLOT_W + WOFS_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_en,
   input  logic [SLOT_W-1:0] own_slot,
   input  logic [PIPE_W-1:0] own_pipe,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic [PIPE_W-1:0] wr_pipe,
   input  logic [WOFS_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              wr_last,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data,
   input  logic              use_req,
   input  logic [SLOT_W-1:0] use_slot,
   input  logic [PIPE_W-1:0] use_pipe,
   input  logic              use_tdes,
   output logic [KEY_W-1:0]  key_out,
   output logic              key_ok,
   input  logic              blk_done,
   input  logic [SLOT_W-1:0] blk_slot
);

   import kv_pkg::*;

   localparam int STAT_W = 2 * NUM_SLOTS + 1;

   // Elaboration-time parameter checks
   generate
      if (NUM_SLOTS < 2 || (1 << SLOT_W) != NUM_SLOTS) begin : g_bad_slots
         $error("key_vault: NUM_SLOTS must be a power of two, at least 2");
      end
      if (NWORDS < 2 || (1 << WOFS_W) != NWORDS) begin : g_bad_words
         $error("key_vault: NWORDS must be a power of two, at least 2");
      end
      if (STAT_W > WORD_W) begin : g_bad_stat
         $error("key_vault: status word does not fit in WORD_W");
      end
      if (WEAR_LIMIT < 1) begin : g_bad_limit
         $error("key_vault: WEAR_LIMIT must be positive");
      end
   endgenerate

   logic [KEY_W-1:0]     slot_key   [NUM_SLOTS];
   logic [PIPE_W-1:0]    slot_owner [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] valid_v;
   logic [NUM_SLOTS-1:0] owned_v;
   logic [NUM_SLOTS-1:0] limit_v;
   logic [NUM_SLOTS-1:0] block_v;
   logic                 err_q;
   kv_deny_e             deny;
   logic                 grant;

   generate
      for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
         kv_slot #(
            .WORD_W (WORD_W),
            .NWORDS (NWORDS),
            .PIPE_W (PIPE_W),
            .LIMIT  (WEAR_LIMIT)
         ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .own_set_i  (own_en && (own_slot == SLOT_W'(i))),
            .own_pipe_i (own_pipe),
            .wr_req_i   (wr_en && (wr_slot == SLOT_W'(i))),
            .wr_pipe_i  (wr_pipe),
            .wr_word_i  (wr_word),
            .wr_data_i  (wr_data),
            .wr_last_i  (wr_last),
            .blk_inc_i  (blk_done && (blk_slot == SLOT_W'(i))),
            .key_o      (slot_key[i]),
            .valid_o    (valid_v[i]),
            .owned_o    (owned_v[i]),
            .owner_o    (slot_owner[i]),
            .limit_o    (limit_v[i]),
            .wr_block_o (block_v[i])
         );
      end
   endgenerate

   // Key request decision: ownership first, then validity, then wear
   always_comb begin
      deny = KV_DENY_NONE;
      if (!owned_v[use_slot] || (slot_owner[use_slot] != use_pipe)) begin
         deny = KV_DENY_OWNER;
      end else if (!valid_v[use_slot]) begin
         deny = KV_DENY_INVALID;
      end else if (use_tdes && limit_v[use_slot]) begin
         deny = KV_DENY_WEAR;
      end
   end

   assign grant = use_req && (deny == KV_DENY_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_out <= '0;
         key_ok  <= 1'b0;
      end else begin
         key_out <= grant ? slot_key[use_slot] : '0;
         key_ok  <= grant;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_q <= 1'b0;
      end else if ((|block_v) || (use_req && (deny != KV_DENY_NONE))) begin
         err_q <= 1'b1;
      end
   end

   kv_rd_port #(
      .WORD_W (WORD_W),
      .ADDR_W (ADDR_W),
      .STAT_W (STAT_W)
   ) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en_i   (rd_en),
      .rd_addr_i (rd_addr),
      .status_i  ({err_q, limit_v, valid_v}),
      .rd_data_o (rd_data)
   );

endmodule

// File: rtl/kv_chk.sv
module kv_chk #(
   parameter int NUM_SLOTS = 4,
   parameter int SLOT_W    = 2,
   parameter int ADDR_W    = 7,
   parameter int WORD_W    = 32,
   parameter int KEY_W     = 512
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 rd_en,
   input logic [ADDR_W-1:0]    rd_addr,
   input logic [WORD_W-1:0]    rd_data,
   input logic                 use_req,
   input logic [SLOT_W-1:0]    use_slot,
   input logic                 use_tdes,
   input logic [KEY_W-1:0]     key_out,
   input logic                 key_ok,
   input logic [NUM_SLOTS-1:0] valid_v,
   input logic [NUM_SLOTS-1:0] limit_v,
   input logic [NUM_SLOTS-1:0] block_v,
   input logic                 err_q
);

   AST_KEYSPACE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_addr[ADDR_W-1]) |=> (rd_data == '0)); // R1

   AST_NO_KEY_WHEN_DENIED: assert property (@(posedge clk) disable iff (!rst_n)
      !key_ok |-> (key_out == '0)); // R7

   AST_NO_GRANT_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && !valid_v[use_slot]) |=> !key_ok); // R7

   AST_NO_GRANT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !use_req |=> !key_ok); // R7

   AST_WEAR_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (use_req && use_tdes && limit_v[use_slot]) |=> !key_ok); // R9

   AST_BLOCK_FLAGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (|block_v) |=> err_q); // R5

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q); // R10

   AST_LIMIT_ON_VALID_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ((limit_v & ~valid_v) == '0)); // R8

endmodule

bind key_vault kv_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .SLOT_W    (SLOT_W),
   .ADDR_W    (ADDR_W),
   .WORD_W    (WORD_W),
   .KEY_W     (KEY_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_addr  (rd_addr),
   .rd_data  (rd_data),
   .use_req  (use_req),
   .use_slot (use_slot),
   .use_tdes (use_tdes),
   .key_out  (key_out),
   .key_ok   (key_ok),
   .valid_v  (valid_v),
   .limit_v  (limit_v),
   .block_v  (block_v),
   .err_q    (err_q)
);

// File: tb/key_vault_tb_top.sv
module key_vault_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NS     = 4;
   localparam int WW     = 32;
   localparam int NW     = 16;
   localparam int PW     = 3;
   localparam int LIM    = 65536;
   localparam int SW     = 2;
   localparam int OW     = 4;
   localparam int KW     = NW * WW;
   localparam int AW     = SW + OW + 1;
   localparam logic [AW-1:0] STAT_A = 7'h40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          own_en = 0;
   logic [SW-1:0] own_slot = '0;
   logic [PW-1:0] own_pipe = '0;
   logic          wr_en = 0;
   logic [SW-1:0] wr_slot = '0;
   logic [PW-1:0] wr_pipe = '0;
   logic [OW-1:0] wr_word = '0;
   logic [WW-1:0] wr_data = '0;
   logic          wr_last = 0;
   logic          rd_en = 0;
   logic [AW-1:0] rd_addr = '0;
   logic [WW-1:0] rd_data;
   logic          use_req = 0;
   logic [SW-1:0] use_slot = '0;
   logic [PW-1:0] use_pipe = '0;
   logic          use_tdes = 0;
   logic [KW-1:0] key_out;
   logic          key_ok;
   logic          blk_done = 0;
   logic [SW-1:0] blk_slot = '0;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   key_vault dut_i (
      .clk(clk), .rst_n(rst_n),
      .own_en(own_en), .own_slot(own_slot), .own_pipe(own_pipe),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_pipe(wr_pipe), .wr_word(wr_word),
      .wr_data(wr_data), .wr_last(wr_last),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
      .use_req(use_req), .use_slot(use_slot), .use_pipe(use_pipe),
      .use_tdes(use_tdes), .key_out(key_out), .key_ok(key_ok),
      .blk_done(blk_done), .blk_slot(blk_slot)
   );

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   function automatic logic [WW-1:0] pat(input int s, input int w, input int gen);
      return 32'hC000_0000 | WW'(gen << 16) | WW'(s << 8) | WW'(w);
   endfunction

   // All bus tasks start and end just after a falling edge
   task automatic do_own(input int s, input int p);
      own_en = 1; own_slot = SW'(s); own_pipe = PW'(p);
      @(negedge clk);
      own_en = 0;
   endtask

   task automatic do_wr(input int s, input int p, input int w, input logic [WW-1:0] d, input bit last);
      wr_en = 1; wr_slot = SW'(s); wr_pipe = PW'(p); wr_word = OW'(w);
      wr_data = d; wr_last = last;
      @(negedge clk);
      wr_en = 0; wr_last = 0;
   endtask

   task automatic do_rd(input logic [AW-1:0] a, output logic [WW-1:0] v);
      rd_en = 1; rd_addr = a;
      @(negedge clk);
      v = rd_data;
      rd_en = 0;
   endtask

   task automatic do_use(input int s, input int p, input bit tdes);
      use_req = 1; use_slot = SW'(s); use_pipe = PW'(p); use_tdes = tdes;
      @(negedge clk);
      use_req = 0; use_tdes = 0;
   endtask

   task automatic strobe(input int s, input int n);
      blk_done = 1; blk_slot = SW'(s);
      repeat (n) @(negedge clk);
      blk_done = 0;
   endtask

   task automatic t_reset_state;
      logic [WW-1:0] v;
      chk("R3 key_ok after reset", 64'(key_ok), 64'd0);
      chk("R3 key_out after reset", key_out[63:0], 64'd0);
      do_rd(STAT_A, v);
      chk("R3 status after reset", 64'(v), 64'h000);
   endtask

   task automatic t_load_and_use;
      logic [WW-1:0] v;
      do_own(0, 1);
      for (int w = 0; w < 8; w++) do_wr(0, 1, w, pat(0, w, 1), 1'b0);
      do_rd(STAT_A, v);
      chk("R6 valid clear mid-load", 64'(v), 64'h000);
      for (int w = 8; w < NW; w++) do_wr(0, 1, w, pat(0, w, 1), w == NW - 1);
      do_rd(STAT_A, v);
      chk("R2 R6 valid after last word", 64'(v), 64'h001);
      do_use(0, 1, 1'b0);
      chk("R7 grant", 64'(key_ok), 64'd1);
      chk("R7 key word0", 64'(key_out[31:0]), 64'(pat(0, 0, 1)));
      chk("R7 key word15", 64'(key_out[KW-1 -: WW]), 64'(pat(0, 15, 1)));
      chk("R7 key word7", 64'(key_out[7*WW +: WW]), 64'(pat(0, 7, 1)));
   endtask

   task automatic t_read_zero;
      logic [WW-1:0] v;
      do_rd(7'h03, v);
      chk("R1 key word read", 64'(v), 64'd0);
      do_rd(7'h0F, v);
      chk("R1 key last word read", 64'(v), 64'd0);
      do_rd(7'h41, v);
      chk("R1 reserved read", 64'(v), 64'd0);
   endtask

   task automatic t_blocked;
      logic [WW-1:0] v;
      do_wr(0, 2, 0, 32'h0BAD_0BAD, 1'b1);
      do_rd(STAT_A, v);
      chk("R5 foreign pipe write blocked, err set", 64'(v), 64'h101);
      do_use(0, 1, 1'b0);
      chk("R5 key unchanged word0", 64'(key_out[31:0]), 64'(pat(0, 0, 1)));
      chk("R5 key unchanged word1", 64'(key_out[63:32]), 64'(pat(0, 1, 1)));
      do_wr(1, 1, 0, 32'h1234_5678, 1'b1);
      do_rd(STAT_A, v);
      chk("R5 unbound slot write blocked", 64'(v), 64'h101);
   endtask

   task automatic t_use_deny;
      do_use(0, 3, 1'b0);
      chk("R7 wrong pipe denied", 64'(key_ok), 64'd0);
      chk("R7 wrong pipe zero key", key_out[63:0], 64'd0);
      do_use(2, 1, 1'b0);
      chk("R7 unbound slot denied", 64'(key_ok), 64'd0);
      chk("R7 unbound slot zero key", key_out[KW-1 -: 64], 64'd0);
   endtask

   task automatic t_wear;
      logic [WW-1:0] v;
      strobe(0, LIM - 1);
      do_rd(STAT_A, v);
      chk("R8 limit clear at 65535", 64'(v), 64'h101);
      strobe(0, 1);
      do_rd(STAT_A, v);
      chk("R8 limit set at 65536", 64'(v), 64'h111);
      do_use(0, 1, 1'b1);
      chk("R9 tdes refused", 64'(key_ok), 64'd0);
      chk("R9 tdes zero key", key_out[63:0], 64'd0);
      do_use(0, 1, 1'b0);
      chk("R9 non-tdes granted", 64'(key_ok), 64'd1);
      chk("R9 non-tdes key", 64'(key_out[31:0]), 64'(pat(0, 0, 1)));
      strobe(0, 3);
      do_rd(STAT_A, v);
      chk("R8 saturated, R10 err held", 64'(v), 64'h111);
      do_wr(0, 1, 0, pat(0, 0, 2), 1'b1);
      do_rd(STAT_A, v);
      chk("R6 rewrite clears limit, R10 err kept", 64'(v), 64'h101);
      do_use(0, 1, 1'b1);
      chk("R6 tdes granted after rewrite", 64'(key_ok), 64'd1);
      chk("R6 new word0", 64'(key_out[31:0]), 64'(pat(0, 0, 2)));
      chk("R6 old word1 gone", 64'(key_out[63:32]), 64'd0);
      chk("R6 old word15 gone", 64'(key_out[KW-1 -: WW]), 64'd0);
   endtask

   task automatic t_reassign;
      logic [WW-1:0] v;
      do_own(0, 5);
      do_rd(STAT_A, v);
      chk("R4 rebind clears valid", 64'(v), 64'h100);
      do_use(0, 5, 1'b0);
      chk("R4 rebound slot has no key", 64'(key_ok), 64'd0);
      do_wr(0, 1, 0, 32'hFFFF_0000, 1'b1);
      do_rd(STAT_A, v);
      chk("R4 R5 old owner blocked", 64'(v), 64'h100);
      do_wr(0, 5, 0, pat(0, 0, 3), 1'b1);
      do_use(0, 5, 1'b0);
      chk("R4 new owner granted", 64'(key_ok), 64'd1);
      chk("R4 new owner key", 64'(key_out[31:0]), 64'(pat(0, 0, 3)));
   endtask

   task automatic t_zeroize;
      logic [WW-1:0] v;
      rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      do_rd(STAT_A, v);
      chk("R3 R10 status zero after reset", 64'(v), 64'h000);
      do_use(0, 5, 1'b0);
      chk("R3 binding gone", 64'(key_ok), 64'd0);
      do_own(0, 5);
      do_use(0, 5, 1'b0);
      chk("R3 key zeroized", 64'(key_ok), 64'd0);
      chk("R3 key_out zero", key_out[63:0], 64'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset_state();
      t_load_and_use();
      t_read_zero();
      t_blocked();
      t_use_deny();
      t_wear();
      t_reassign();
      t_zeroize();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule